// File: doc/BRIEF.md
# Time-Multiplexed Four-Input LUT Tile

This block is a small reconfigurable logic tile whose cells are reused over time. It holds an array of four-input lookup cells. Every cell keeps a separate truth table, enable flag and set of input selects for each context slot. A context counter sweeps the slots one per clock, so a single physical cell can compute a different function at each step of one evaluation. A counter-controlled sequence of contexts replaces a wide spatial netlist with a narrow one that is evaluated in several passes.

Each cell drives its own retiming register. The register updates only in contexts where the cell is enabled and otherwise keeps its value. An intermediate result can therefore be produced early and consumed several contexts later. Cell inputs pick from the primary inputs latched at start or from any retiming register.

A host loads the slots through a write port while the tile is idle. It then sets the number of contexts, pulses `start` with the primary inputs present, and collects the result on `dout` when `done` pulses.

Top module: `mctx_lut_tile`

## Requirements
- R1: After reset, `done` is 0 and `dout` is all zeros, and every stored slot is disabled.
- R2: An enabled cell in a context produces bit `tt[{in3,in2,in1,in0}]` of the truth table stored for that cell and context, where `tt` is written through `cfg_tt[15:0]`.
- R3: Cell input i uses the 5-bit select `cfg_sel[5i+4:5i]` stored for that context. Values 0..7 pick latched primary input bit v. Values 8..23 pick the retiming register of cell v-8. Values 24..31 give a constant 0.
- R4: `ctx_last` holds the number of contexts minus one. The context index runs 0,1,..,`ctx_last`, one per clock. `done` is high for exactly one cycle, `ctx_last`+2 clock edges after the edge that accepts `start`.
- R5: A value a cell writes in context k is seen by readers from context k+1 onward. A cell that selects its own register reads the value from before the current context.
- R6: A cell whose slot is disabled in a context keeps its retiming register unchanged through that context.
- R7: An accepted `start` latches `pi` and clears every retiming register to 0. Later changes of `pi` during the evaluation do not affect the result.
- R8: `start` is accepted only while the tile is idle. A `start` during an evaluation neither restarts it nor delays `done`.
- R9: A configuration write takes effect only while the tile is idle. A write during an evaluation leaves the stored slots unchanged.
- R10: When `done` rises, `dout[j]` equals the retiming register of cell j after the last context. `dout` then holds until the next `done`.
- R11: Loaded with a three-context mapping, the tile converts each of the 22 hex characters '0'-'9', 'a'-'f', 'A'-'F' to its 4-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_lut | input | 4 | Cell index of the write |
| cfg_ctx | input | 3 | Context index of the write |
| cfg_en | input | 1 | Enable flag of the slot |
| cfg_tt | input | 16 | Truth table of the slot |
| cfg_sel | input | 20 | Four 5-bit input selects, input i at bits 5i+4:5i |
| ctx_last | input | 3 | Number of contexts minus one, sampled at start |
| start | input | 1 | Begin an evaluation (accepted when idle) |
| pi | input | 8 | Primary inputs, latched at start |
| done | output | 1 | One-cycle completion pulse |
| dout | output | 4 | Retiming registers of cells 0..3 after the last context |

## Verification
Two functions can meet in one cycle: a slot write and an evaluation that is reading the slots, or a new `start` and a running sweep. The bench provokes both by driving a corrupting slot write, and in another run a second `start` pulse, one cycle into a hex conversion. It judges the outcome by the value and arrival cycle of that result and by the result of the next conversion, which would expose a slot that the write had altered.

// File: rtl/mctx_pkg.sv
package mctx_pkg;
    localparam int LUT_K = 4;
    localparam int TT_W  = 1 << LUT_K;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_FIN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/mctx_ctx_seq.sv
module mctx_ctx_seq
    import mctx_pkg::*;
#(
    parameter int N_CTX = 8,
    localparam int CTX_W = $clog2(N_CTX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CTX_W-1:0] ctx_last,
    output logic             idle,
    output logic             run,
    output logic             fin,
    output logic [CTX_W-1:0] ctx
);
    typedef struct packed {
        seq_state_e       st;
        logic [CTX_W-1:0] ctx;
        logic [CTX_W-1:0] last;
    } seq_t;

    seq_t sq_d, sq_q;
    logic [CTX_W-1:0] last_cl;

    always_comb begin
        last_cl = (int'(ctx_last) >= N_CTX) ? CTX_W'(N_CTX - 1) : ctx_last;
        sq_d = sq_q;
        case (sq_q.st)
            SQ_IDLE: begin
                if (start) begin
                    sq_d.st   = SQ_RUN;
                    sq_d.ctx  = '0;
                    sq_d.last = last_cl;
                end
            end
            SQ_RUN: begin
                if (sq_q.ctx == sq_q.last) sq_d.st = SQ_FIN;
                else                       sq_d.ctx = sq_q.ctx + 1'b1;
            end
            default: sq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '{st: SQ_IDLE, ctx: '0, last: '0};
        else        sq_q <= sq_d;
    end

    assign idle = (sq_q.st == SQ_IDLE);
    assign run  = (sq_q.st == SQ_RUN);
    assign fin  = (sq_q.st == SQ_FIN);
    assign ctx  = sq_q.ctx;

    AST_CTX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ctx <= sq_q.last);                                   // R4
    AST_CTX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && ctx != sq_q.last |=> run && ctx == CTX_W'($past(ctx) + 1)); // R4
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !idle && start |=> !(run && ctx == '0 && $past(ctx) != '0)); // R8
endmodule

// File: rtl/mctx_cfg_store.sv
module mctx_cfg_store #(
    parameter int N_LUT = 16,
    parameter int N_CTX = 8,
    parameter int CFG_W = 37,
    localparam int LUT_W = $clog2(N_LUT),
    localparam int CTX_W = $clog2(N_CTX)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic                        wr_ok,
    input  logic [LUT_W-1:0]            wlut,
    input  logic [CTX_W-1:0]            wctx,
    input  logic [CFG_W-1:0]            wdata,
    input  logic [CTX_W-1:0]            rctx,
    output logic [N_LUT-1:0][CFG_W-1:0] rdata
);
    logic [N_LUT-1:0][N_CTX-1:0][CFG_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we && wr_ok && int'(wlut) < N_LUT && int'(wctx) < N_CTX)
            mem_d[wlut][wctx] = wdata;
        for (int l = 0; l < N_LUT; l++)
            rdata[l] = mem_q[l][rctx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    AST_WRITE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        we && !wr_ok |=> mem_q[$past(wlut)][$past(wctx)] == $past(mem_q[wlut][wctx])); // R9
endmodule

// File: rtl/mctx_lut_cell.sv
module mctx_lut_cell
    import mctx_pkg::*;
#(
    parameter int N_SRC = 24,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic [TT_W-1:0]        tt,
    input  logic [LUT_K*SEL_W-1:0] sel,
    input  logic [N_SRC-1:0]       src,
    output logic                   y
);
    logic [LUT_K-1:0] addr;
    logic [SEL_W-1:0] s_v [LUT_K];

    always_comb begin
        for (int i = 0; i < LUT_K; i++) begin
            s_v[i]  = sel[i*SEL_W +: SEL_W];
            addr[i] = (int'(s_v[i]) < N_SRC) ? src[s_v[i]] : 1'b0;
        end
        y = tt[addr];
    end
endmodule

// File: rtl/mctx_lut_tile.sv
module mctx_lut_tile
    import mctx_pkg::*;
#(
    parameter int N_LUT = 16,
    parameter int N_CTX = 8,
    parameter int N_PI  = 8,
    parameter int N_PO  = 4,
    localparam int LUT_W  = $clog2(N_LUT),
    localparam int CTX_W  = $clog2(N_CTX),
    localparam int N_SRC  = N_PI + N_LUT,
    localparam int SEL_W  = $clog2(N_SRC),
    localparam int SELV_W = LUT_K * SEL_W,
    localparam int CFG_W  = 1 + SELV_W + TT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [LUT_W-1:0]  cfg_lut,
    input  logic [CTX_W-1:0]  cfg_ctx,
    input  logic              cfg_en,
    input  logic [TT_W-1:0]   cfg_tt,
    input  logic [SELV_W-1:0] cfg_sel,
    input  logic [CTX_W-1:0]  ctx_last,
    input  logic              start,
    input  logic [N_PI-1:0]   pi,
    output logic              done,
    output logic [N_PO-1:0]   dout
);
    typedef struct packed {
        logic [N_PI-1:0]  pi;
        logic [N_LUT-1:0] lut;
        logic [N_PO-1:0]  dout;
        logic             done;
    } tile_t;

    tile_t st_d, st_q;
    logic idle, run, fin;
    logic [CTX_W-1:0] ctx;
    logic [N_LUT-1:0][CFG_W-1:0] cfg_rd;
    logic [N_LUT-1:0] lut_y, lut_en;

    mctx_ctx_seq #(.N_CTX(N_CTX)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .ctx_last(ctx_last),
        .idle(idle), .run(run), .fin(fin), .ctx(ctx)
    );

    mctx_cfg_store #(.N_LUT(N_LUT), .N_CTX(N_CTX), .CFG_W(CFG_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wr_ok(idle),
        .wlut(cfg_lut), .wctx(cfg_ctx), .wdata({cfg_en, cfg_sel, cfg_tt}),
        .rctx(ctx), .rdata(cfg_rd)
    );

    for (genvar g = 0; g < N_LUT; g++) begin : g_cell
        assign lut_en[g] = cfg_rd[g][CFG_W-1];
        mctx_lut_cell #(.N_SRC(N_SRC)) u_cell (
            .tt(cfg_rd[g][TT_W-1:0]),
            .sel(cfg_rd[g][TT_W +: SELV_W]),
            .src({st_q.lut, st_q.pi}),
            .y(lut_y[g])
        );

        AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
            run && !lut_en[g] |=> $stable(st_q.lut[g]));              // R6
    end

    always_comb begin
        st_d = st_q;
        st_d.done = 1'b0;
        if (idle && start) begin
            st_d.pi  = pi;
            st_d.lut = '0;
        end
        if (run) begin
            for (int l = 0; l < N_LUT; l++)
                if (lut_en[l]) st_d.lut[l] = lut_y[l];
        end
        if (fin) begin
            st_d.dout = st_q.lut[N_PO-1:0];
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
    assign dout = st_q.dout;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R4
    AST_PI_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(st_q.pi));                                    // R7
    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(dout));                                      // R10
endmodule

// File: tb/mctx_lut_tile_tb.sv
`timescale 1ns/1ps
module mctx_lut_tile_tb;
    localparam int NL = 16, NC = 8, K = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_en = 1'b0, start = 1'b0;
    logic [3:0] cfg_lut = '0;
    logic [2:0] cfg_ctx = '0, ctx_last = '0;
    logic [15:0] cfg_tt = '0;
    logic [19:0] cfg_sel = '0;
    logic [7:0] pi = '0;
    logic done;
    logic [3:0] dout;

    int checks = 0, errors = 0;
    logic [15:0] sh_tt [NL][NC];
    logic [4:0]  sh_sel [NL][NC][K];
    logic        sh_en [NL][NC];

    always #2.5 clk = ~clk;

    mctx_lut_tile u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lut(cfg_lut),
        .cfg_ctx(cfg_ctx), .cfg_en(cfg_en), .cfg_tt(cfg_tt), .cfg_sel(cfg_sel),
        .ctx_last(ctx_last), .start(start), .pi(pi), .done(done), .dout(dout)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // op: 0 AND(in0,in1), 1 XOR(in0,in1), 2 OR(in0,in1), 3 copy in0, 4 in0?in1:in2, 5 NOT in0
    function automatic logic [15:0] mk(input int op);
        logic [15:0] t;
        for (int a = 0; a < 16; a++) begin
            logic [3:0] v;
            v = 4'(a);
            case (op)
                0: t[a] = v[0] & v[1];
                1: t[a] = v[0] ^ v[1];
                2: t[a] = v[0] | v[1];
                3: t[a] = v[0];
                4: t[a] = v[0] ? v[1] : v[2];
                default: t[a] = ~v[0];
            endcase
        end
        return t;
    endfunction

    task automatic put(input int l, input int c, input bit en, input logic [15:0] tt,
                       input int s0, input int s1, input int s2, input int s3);
        @(negedge clk);
        cfg_we = 1'b1; cfg_lut = 4'(l); cfg_ctx = 3'(c); cfg_en = en; cfg_tt = tt;
        cfg_sel = {5'(s3), 5'(s2), 5'(s1), 5'(s0)};
        @(negedge clk);
        cfg_we = 1'b0;
        sh_en[l][c] = en; sh_tt[l][c] = tt;
        sh_sel[l][c][0] = 5'(s0); sh_sel[l][c][1] = 5'(s1);
        sh_sel[l][c][2] = 5'(s2); sh_sel[l][c][3] = 5'(s3);
    endtask

    task automatic clear_all();
        for (int l = 0; l < NL; l++)
            for (int c = 0; c < NC; c++)
                put(l, c, 1'b0, 16'h0, 31, 31, 31, 31);
    endtask

    function automatic logic [3:0] model(input logic [7:0] p, input int last);
        logic [15:0] r, nr;
        r = '0;
        for (int c = 0; c <= last; c++) begin
            nr = r;
            for (int l = 0; l < NL; l++) begin
                if (sh_en[l][c]) begin
                    logic [3:0] ad;
                    for (int i = 0; i < K; i++) begin
                        int s;
                        s = int'(sh_sel[l][c][i]);
                        ad[i] = (s < 8) ? p[s] : (s < 24) ? r[s-8] : 1'b0;
                    end
                    nr[l] = sh_tt[l][c][ad];
                end
            end
            r = nr;
        end
        return r[3:0];
    endfunction

    function automatic logic [3:0] hexval(input logic [7:0] ch);
        if (ch >= "0" && ch <= "9") return 4'(ch - "0");
        if (ch >= "a" && ch <= "f") return 4'(ch - "a" + 10);
        return 4'(ch - "A" + 10);
    endfunction

    // mode: 0 plain, 1 change pi while running, 2 second start, 3 slot write while running
    task automatic run_eval(input logic [7:0] p, input int last, input int mode,
                            output logic [3:0] res, output int cyc);
        @(negedge clk);
        pi = p; ctx_last = 3'(last); start = 1'b1;
        @(negedge clk);
        start = 1'b0; cyc = 0;
        while (1) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (mode == 1) pi = 8'($urandom);
            start = (mode == 2 && cyc == 1);
            if (mode == 3 && cyc == 1) begin
                cfg_we = 1'b1; cfg_lut = 4'd0; cfg_ctx = 3'd2; cfg_en = 1'b1;
                cfg_tt = 16'hFFFF; cfg_sel = '1;
            end else cfg_we = 1'b0;
            if (done || cyc > 40) break;
        end
        start = 1'b0; cfg_we = 1'b0;
        if (cyc > 40) chk(1'b0, "R4 done timeout", 32'(cyc), 32'(last + 2));
        res = dout;
    endtask

    task automatic load_hex();
        clear_all();
        put(4, 0, 1, mk(0), 1, 0, 31, 31);
        put(5, 0, 1, mk(3), 6, 31, 31, 31);
        put(6, 0, 1, mk(1), 1, 0, 31, 31);
        put(4, 1, 1, mk(2), 2, 12, 31, 31);
        put(7, 1, 1, mk(4), 13, 14, 1, 31);
        put(0, 2, 1, mk(1), 0, 13, 31, 31);
        put(1, 2, 1, mk(3), 15, 31, 31, 31);
        put(2, 2, 1, mk(4), 13, 12, 2, 31);
        put(3, 2, 1, mk(2), 13, 3, 31, 31);
    endtask

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        string hexs;
        logic [3:0] res, prev;
        int cyc;
        void'($urandom(1234));
        hexs = "0123456789abcdefABCDEF";

        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done after reset", 32'(done), 0);
        chk(dout == 4'h0, "R1 dout after reset", 32'(dout), 0);
        rst_n = 1'b1;
        for (int l = 0; l < NL; l++)
            for (int c = 0; c < NC; c++) begin
                sh_en[l][c] = 1'b0; sh_tt[l][c] = '0;
                for (int i = 0; i < K; i++) sh_sel[l][c][i] = '0;
            end
        run_eval(8'hFF, 7, 0, res, cyc);
        chk(res == 4'h0, "R1 unprogrammed slots idle", 32'(res), 0);

        load_hex();
        for (int i = 0; i < 22; i++) begin
            logic [7:0] ch;
            ch = hexs[i];
            run_eval(ch, 2, 0, res, cyc);
            chk(res == hexval(ch), "R11 hex conversion", 32'(res), 32'(hexval(ch)));
            chk(cyc == 4, "R4 latency three contexts", 32'(cyc), 4);
            if (i == 0) begin
                @(negedge clk);
                chk(done == 1'b0, "R4 done one cycle", 32'(done), 0);
            end
        end

        run_eval("c", 2, 0, res, cyc);
        prev = res;
        pi = "7";
        repeat (3) @(negedge clk);
        chk(dout == prev, "R10 dout held", 32'(dout), 32'(prev));

        run_eval("E", 2, 1, res, cyc);
        chk(res == 4'hE, "R7 pi change ignored", 32'(res), 32'hE);

        run_eval("9", 2, 2, res, cyc);
        chk(res == 4'h9, "R8 second start result", 32'(res), 32'h9);
        chk(cyc == 4, "R8 second start timing", 32'(cyc), 4);

        run_eval("a", 2, 3, res, cyc);
        chk(res == 4'hA, "R9 busy write result", 32'(res), 32'hA);
        run_eval("4", 2, 0, res, cyc);
        chk(res == 4'h4, "R9 slots unchanged after busy write", 32'(res), 32'h4);

        clear_all();
        put(0, 0, 1, mk(3), 0, 31, 31, 31);
        run_eval(8'h01, 0, 0, res, cyc);
        chk(res[0] == 1'b1, "R2 single context copy", 32'(res), 1);
        chk(cyc == 2, "R4 latency one context", 32'(cyc), 2);
        put(0, 0, 0, mk(3), 0, 31, 31, 31);
        run_eval(8'h01, 0, 0, res, cyc);
        chk(res[0] == 1'b0, "R7 registers cleared at start", 32'(res), 0);

        put(0, 0, 1, mk(5), 26, 31, 31, 31);
        put(1, 0, 1, mk(3), 0, 31, 31, 31);
        put(2, 0, 1, mk(3), 9, 31, 31, 31);
        put(1, 1, 1, mk(1), 9, 1, 31, 31);
        put(3, 1, 1, mk(3), 9, 31, 31, 31);
        run_eval(8'h01, 1, 0, res, cyc);
        chk(res[0] == 1'b1, "R3 out-of-range select reads 0", 32'(res[0]), 1);
        chk(res[2] == 1'b0, "R5 same-context read sees old", 32'(res[2]), 0);
        chk(res[3] == 1'b1, "R5 next-context read sees new", 32'(res[3]), 1);
        chk(res[1] == 1'b1, "R5 own register feedback", 32'(res[1]), 1);
        run_eval(8'h03, 1, 0, res, cyc);
        chk(res[1] == 1'b0, "R5 own register feedback xor", 32'(res[1]), 0);

        for (int n = 0; n < 40; n++) begin
            for (int l = 0; l < NL; l++)
                for (int c = 0; c < NC; c++)
                    put(l, c, 1'($urandom), 16'($urandom), $urandom % 32,
                        $urandom % 32, $urandom % 32, $urandom % 32);
            for (int r = 0; r < 4; r++) begin
                logic [7:0] p;
                int last;
                logic [3:0] exp;
                p = 8'($urandom);
                last = $urandom % 8;
                exp = model(p, last);
                run_eval(p, last, 0, res, cyc);
                chk(res == exp, "R2 R3 R6 R10 random program", 32'(res), 32'(exp));
                chk(cyc == last + 2, "R4 random latency", 32'(cyc), 32'(last + 2));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule